// File: doc/BRIEF.md
# PCI Target Address-Phase Decoder

This block watches a PCI bus for the start of each transaction and decides, from the address phase alone, whether a single-function target has to respond. The start is the first clock on which FRAME# is low after a clock on which it was high. On that edge the block looks at the address bus, the command on C/BE#, IDSEL, and the window settings supplied by an external configuration register block. It then reports whether the transaction is claimed and which internal space it goes to: configuration space, a 32-byte I/O-mapped register window, or a 4096-byte memory-mapped register window.

The bus command is reduced to a plain read or write flag. The extended memory commands are folded onto plain memory read and write. Commands the target never answers are dropped. Each window has its own enable, and a configuration access needs function number zero. The decoder also gives the DWord offset inside the selected space and the byte enables of the first data phase. Data-phase handshaking, the registers themselves and master operation belong to other blocks.

Top module: `pci_tgt_decode`

## Requirements
- R1: After a synchronous active-low reset, `claim_o`=0, `space_o`=2'b00, `wr_o`=0, `dw_ofs_o`=0 and `be_n_o`=4'hF.
- R2: The address phase is the first clock with `frame_n` low after a clock with `frame_n` high. The decode result is registered on that edge and appears on the next clock. `claim_o` is a pulse of one clock. Clocks during which `frame_n` stays low produce no new decode.
- R3: A configuration access is claimed (`space_o`=2'b01) only when all of these hold: `idsel` is 1, `ad[1:0]`=0, `ad[10:8]`=0, and the command is 4'b1010 (read) or 4'b1011 (write). `ad[31:11]` do not matter.
- R4: For a configuration access, `dw_ofs_o` equals `ad[7:2]`, zero-extended.
- R5: Command 4'b0010 or 4'b0011 is claimed as I/O (`space_o`=2'b10) only when `ioen` is 1 and `ad[31:5]` equals `io_base[31:5]`. `dw_ofs_o` is then `ad[4:2]`.
- R6: Commands 4'b0110 and 4'b0111 are claimed as memory (`space_o`=2'b11) only when `memen` is 1 and `ad[31:12]` equals `mem_base[31:12]`. `dw_ofs_o` is then `ad[11:2]`.
- R7: Commands 4'b1100 and 4'b1110 decode as memory read. Command 4'b1111 decodes as memory write.
- R8: `wr_o` is 1 for commands 4'b0011, 4'b0111, 4'b1011 and 4'b1111 and 0 for the other claimed commands. Commands 4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001 and 4'b1101 are never claimed.
- R9: An address phase that does not match gives `space_o`=2'b00, `wr_o`=0 and `dw_ofs_o`=0. These values hold until the next address phase.
- R10: The value on `cbe_n` in the clock after the address phase is captured. It appears on `be_n_o` one clock after `claim_o` and is held until the next transaction's first data phase.
- R11: A new address phase that follows a single high clock of `frame_n`, with no idle clock after the previous transaction's data phase, is decoded exactly as one that follows idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Bus FRAME#, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| idsel | input | 1 | Configuration select for this device |
| ioen | input | 1 | I/O window enable from the configuration registers |
| memen | input | 1 | Memory window enable from the configuration registers |
| io_base | input | 32 | I/O window base; bits [31:5] are compared |
| mem_base | input | 32 | Memory window base; bits [31:12] are compared |
| claim_o | output | 1 | One-clock strobe: the transaction is claimed |
| space_o | output | 2 | 00 none, 01 configuration, 10 I/O, 11 memory |
| wr_o | output | 1 | 1 for a write request |
| dw_ofs_o | output | 10 | DWord offset inside the selected space |
| be_n_o | output | 4 | Byte enables latched from the first data phase |

## Verification
Under back-to-back traffic two things happen on adjacent clocks. In the single clock when `frame_n` is high between two transactions, the decoder captures the byte enables of the ending transaction and also re-arms its start detector. On the very next clock it decodes a new command. The bench provokes this with runs of single-data-phase transactions and no idle clocks, and mixes them with longer bursts and idle gaps. On every clock a behavioural reference model checks that the new decode neither loses nor overwrites the previous byte enables and that no data phase is taken for an address.

// File: rtl/pci_dec_pkg.sv
// Package: shared types for the PCI target address-phase decoder.
// Assumes 4-bit PCI bus commands as they appear on C/BE# in the address phase.
package pci_dec_pkg;
    typedef enum logic [1:0] {
        SP_NONE = 2'b00,
        SP_CFG  = 2'b01,
        SP_IO   = 2'b10,
        SP_MEM  = 2'b11
    } space_e;
endpackage

// File: rtl/pci_cmd_map.sv
// Module: pci_cmd_map
// Reduces a PCI bus command to a target space class and a write flag.
// Extended memory commands fold onto plain read/write. Commands the target
// never answers map to SP_NONE. Purely combinational.
module pci_cmd_map
    import pci_dec_pkg::*;
(
    input  logic [3:0] cmd,
    output space_e     cls,
    output logic       wr
);
    // Command classification table.
    always_comb begin
        cls = SP_NONE;
        wr  = 1'b0;
        unique case (cmd)
            4'b0010: cls = SP_IO;
            4'b0011: begin cls = SP_IO;  wr = 1'b1; end
            4'b0110: cls = SP_MEM;
            4'b0111: begin cls = SP_MEM; wr = 1'b1; end
            4'b1010: cls = SP_CFG;
            4'b1011: begin cls = SP_CFG; wr = 1'b1; end
            4'b1100: cls = SP_MEM;
            4'b1110: cls = SP_MEM;
            4'b1111: begin cls = SP_MEM; wr = 1'b1; end
            default: begin cls = SP_NONE; wr = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pci_win_match.sv
// Module: pci_win_match
// Checks an address against a naturally aligned window of 2**LO_BIT bytes.
// Only bits [AW-1:LO_BIT] are compared. The base is assumed to be aligned.
module pci_win_match #(
    parameter int AW     = 32,
    parameter int LO_BIT = 5
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic          en,
    output logic          hit
);
    localparam int CW = AW - LO_BIT;

    logic [CW-1:0] addr_hi;
    logic [CW-1:0] base_hi;

    // Extract the compared upper bits.
    assign addr_hi = addr[AW-1:LO_BIT];
    assign base_hi = base[AW-1:LO_BIT];

    // The window hits only when it is enabled and the upper bits are equal.
    always_comb hit = en && (addr_hi == base_hi);
endmodule

// File: rtl/pci_tgt_decode.sv
// Module: pci_tgt_decode
// Decodes the PCI address phase for a single-function target. The address
// phase is detected as FRAME# low after a high clock. On that edge the block
// registers the claim decision, target space, read/write flag and DWord
// offset. The byte enables of the next clock are latched separately.
// Assumes MEM_LO >= 8, so that the offset field holds the config index.
module pci_tgt_decode
    import pci_dec_pkg::*;
#(
    parameter int AW     = 32,
    parameter int IO_LO  = 5,
    parameter int MEM_LO = 12,
    parameter int BEW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [AW-1:0]     ad,
    input  logic [BEW-1:0]    cbe_n,
    input  logic              idsel,
    input  logic              ioen,
    input  logic              memen,
    input  logic [AW-1:0]     io_base,
    input  logic [AW-1:0]     mem_base,
    output logic              claim_o,
    output logic [1:0]        space_o,
    output logic              wr_o,
    output logic [MEM_LO-3:0] dw_ofs_o,
    output logic [BEW-1:0]    be_n_o
);
    localparam int OFS_W = MEM_LO - 2;

    logic          frame_q;
    logic          start;
    logic          start_q;
    space_e        cls;
    logic          cls_wr;
    logic          io_hit;
    logic          mem_hit;
    logic          cfg_hit;
    space_e        sel;
    logic [OFS_W-1:0] ofs_nxt;

    // Command classification.
    pci_cmd_map u_cmd (.cmd(cbe_n), .cls(cls), .wr(cls_wr));

    // I/O window comparison.
    pci_win_match #(.AW(AW), .LO_BIT(IO_LO)) u_io_win (
        .addr(ad), .base(io_base), .en(ioen), .hit(io_hit));

    // Memory window comparison.
    pci_win_match #(.AW(AW), .LO_BIT(MEM_LO)) u_mem_win (
        .addr(ad), .base(mem_base), .en(memen), .hit(mem_hit));

    // Address-phase detector: FRAME# low now, high on the previous clock.
    always_comb start = !frame_n && frame_q;

    // Function-zero configuration select.
    always_comb cfg_hit = idsel && (ad[1:0] == 2'b00) && (ad[10:8] == 3'b000);

    // Final space selection and offset extraction.
    always_comb begin
        sel     = SP_NONE;
        ofs_nxt = '0;
        unique case (cls)
            SP_CFG: if (cfg_hit) begin
                sel     = SP_CFG;
                ofs_nxt = OFS_W'(ad[7:2]);
            end
            SP_IO: if (io_hit) begin
                sel     = SP_IO;
                ofs_nxt = OFS_W'(ad[IO_LO-1:2]);
            end
            SP_MEM: if (mem_hit) begin
                sel     = SP_MEM;
                ofs_nxt = ad[MEM_LO-1:2];
            end
            default: sel = SP_NONE;
        endcase
    end

    // Track the previous FRAME# level and mark the first data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b1;
            start_q <= 1'b0;
        end else begin
            frame_q <= frame_n;
            start_q <= start;
        end
    end

    // Register the decode result on each address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim_o  <= 1'b0;
            space_o  <= SP_NONE;
            wr_o     <= 1'b0;
            dw_ofs_o <= '0;
        end else if (start) begin
            claim_o  <= (sel != SP_NONE);
            space_o  <= sel;
            wr_o     <= (sel != SP_NONE) && cls_wr;
            dw_ofs_o <= ofs_nxt;
        end else begin
            claim_o  <= 1'b0;
        end
    end

    // Latch the byte enables of the first data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       be_n_o <= '1;
        else if (start_q) be_n_o <= cbe_n;
    end

    // A claim follows a clock on which FRAME# was low.
    assert_claim_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> $past(!frame_n));

    // A claim never lasts two clocks.
    assert_claim_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |=> !claim_o);

    // A configuration claim needs IDSEL and function zero.
    assert_cfg_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && space_o == SP_CFG) |-> ($past(idsel) && $past(ad[10:8]) == 3'b000));

    // An I/O claim needs the I/O enable.
    assert_io_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && space_o == SP_IO) |-> $past(ioen));

    // A memory claim needs the memory enable.
    assert_mem_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && space_o == SP_MEM) |-> $past(memen));

    // Ignored commands are never claimed.
    assert_no_ignored_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> !($past(cbe_n) == 4'b0000 || $past(cbe_n) == 4'b0001 ||
                      $past(cbe_n) == 4'b0100 || $past(cbe_n) == 4'b0101 ||
                      $past(cbe_n) == 4'b1000 || $past(cbe_n) == 4'b1001 ||
                      $past(cbe_n) == 4'b1101));

    // A claim always carries a space.
    assert_claim_has_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (space_o != SP_NONE));
endmodule

// File: tb/pci_tgt_decode_bench.sv
// Bench for pci_tgt_decode. A behavioural reference model is compared with
// the outputs on every clock, at the falling edge.
module pci_tgt_decode_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        idsel = 1'b0;
    logic        ioen = 1'b0;
    logic        memen = 1'b0;
    logic [31:0] io_base = 32'h0000_C020;
    logic [31:0] mem_base = 32'hFEB0_3000;
    logic        claim_o;
    logic [1:0]  space_o;
    logic        wr_o;
    logic [9:0]  dw_ofs_o;
    logic [3:0]  be_n_o;

    int    vectors = 0;
    int    misses = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    pci_tgt_decode u_pci_tgt_decode (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
        .idsel(idsel), .ioen(ioen), .memen(memen), .io_base(io_base),
        .mem_base(mem_base), .claim_o(claim_o), .space_o(space_o),
        .wr_o(wr_o), .dw_ofs_o(dw_ofs_o), .be_n_o(be_n_o));

    always #10 clk = ~clk;

    // Reference model
    bit       m_prev_f;
    bit       m_prev_start;
    bit       e_claim;
    int       e_space;
    bit       e_wr;
    int       e_ofs;
    bit [3:0] e_be;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev_f     = 1'b1;
            m_prev_start = 1'b0;
            e_claim = 0; e_space = 0; e_wr = 0; e_ofs = 0; e_be = 4'hF;
        end else begin
            bit st;
            st = (frame_n == 1'b0) && m_prev_f;
            if (m_prev_start) e_be = cbe_n;
            if (st) begin
                int sp; bit w; int o;
                sp = 0; w = 0; o = 0;
                case (cbe_n)
                    4'b1010, 4'b1011:
                        if (idsel && ad[1:0] == 0 && ad[10:8] == 0) begin
                            sp = 1; o = ad[7:2];
                        end
                    4'b0010, 4'b0011:
                        if (ioen && (ad / 32) == (io_base / 32)) begin
                            sp = 2; o = ad[4:2];
                        end
                    4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111:
                        if (memen && (ad / 4096) == (mem_base / 4096)) begin
                            sp = 3; o = (ad % 4096) / 4;
                        end
                    default: sp = 0;
                endcase
                if (sp != 0)
                    w = (cbe_n == 4'b0011 || cbe_n == 4'b0111 ||
                         cbe_n == 4'b1011 || cbe_n == 4'b1111);
                e_claim = (sp != 0); e_space = sp; e_wr = w; e_ofs = o;
            end else begin
                e_claim = 0;
            end
            m_prev_start = st;
            m_prev_f     = frame_n;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (checking && !finished) begin
            vectors++;
            if (claim_o !== e_claim || space_o !== 2'(e_space) || wr_o !== e_wr ||
                dw_ofs_o !== 10'(e_ofs) || be_n_o !== e_be) begin
                misses++;
                $display("FAIL %s: got claim=%0b space=%0d wr=%0b ofs=%0d be=%h expected claim=%0b space=%0d wr=%0b ofs=%0d be=%h",
                         cur_req, claim_o, space_o, wr_o, dw_ofs_o, be_n_o,
                         e_claim, e_space, e_wr, e_ofs, e_be);
            end
        end
    end

    task automatic drive(input bit f, input logic [31:0] a, input logic [3:0] c);
        @(posedge clk);
        #2;
        frame_n = f; ad = a; cbe_n = c;
    endtask

    // One transaction: address phase, ndata data phases, then idle clocks.
    task automatic txn(input logic [31:0] a, input logic [3:0] cmd,
                       input logic [3:0] be, input int ndata, input int idle);
        drive(1'b0, a, cmd);
        for (int i = 1; i <= ndata; i++)
            drive((i == ndata) ? 1'b1 : 1'b0, $urandom, be);
        for (int i = 0; i < idle; i++)
            drive(1'b1, $urandom, 4'hF);
    endtask

    function automatic logic [31:0] pick_addr(input int k);
        case (k % 4)
            0: return {io_base[31:5], 5'($urandom)};
            1: return {mem_base[31:12], 12'($urandom)};
            2: return {21'($urandom), 3'b000, 6'($urandom), 2'b00};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2 checking = 1'b1;
        cur_req = "R1";
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;

        // R3 R4: configuration, accepted and rejected forms.
        cur_req = "R3";
        idsel = 1'b1;
        txn(32'hABCD_E0FC, 4'b1010, 4'h0, 1, 1);
        txn(32'h0000_0044, 4'b1011, 4'h3, 2, 1);
        txn(32'h0000_0144, 4'b1010, 4'h0, 1, 1);
        txn(32'h0000_0045, 4'b1010, 4'h0, 1, 1);
        cur_req = "R4";
        txn(32'hFFFF_F8A8, 4'b1011, 4'hE, 1, 1);
        idsel = 1'b0;
        txn(32'h0000_0044, 4'b1010, 4'h0, 1, 1);

        // R5: I/O window with and without enable.
        cur_req = "R5";
        txn(32'h0000_C02C, 4'b0010, 4'h0, 1, 1);
        ioen = 1'b1;
        txn(32'h0000_C02C, 4'b0010, 4'h5, 1, 1);
        txn(32'h0000_C03F, 4'b0011, 4'h7, 3, 0);
        txn(32'h0000_C040, 4'b0011, 4'h0, 1, 1);

        // R6 R7: memory window and aliased commands.
        cur_req = "R6";
        txn(32'hFEB0_3FFC, 4'b0110, 4'h0, 1, 1);
        memen = 1'b1;
        txn(32'hFEB0_3FFC, 4'b0110, 4'h1, 1, 1);
        txn(32'hFEB0_4000, 4'b0111, 4'h0, 1, 1);
        cur_req = "R7";
        txn(32'hFEB0_3010, 4'b1100, 4'h2, 1, 1);
        txn(32'hFEB0_3020, 4'b1110, 4'h4, 2, 1);
        txn(32'hFEB0_3030, 4'b1111, 4'h8, 1, 1);

        // R8: ignored commands aimed at every space.
        cur_req = "R8";
        idsel = 1'b1;
        for (int c = 0; c < 16; c++)
            txn(pick_addr(c), 4'(c), 4'h0, 1, 0);

        // R9: unmatched decode clears space and holds.
        cur_req = "R9";
        txn(32'h1234_5678, 4'b0110, 4'h9, 1, 3);

        // R2 R10: long burst, data phases must not be decoded.
        cur_req = "R2";
        drive(1'b0, 32'h0000_C024, 4'b0011);
        for (int i = 0; i < 5; i++) drive(1'b0, 32'hFEB0_3000, 4'b0111);
        drive(1'b1, 32'h0, 4'h0);
        cur_req = "R10";
        txn(32'hFEB0_3004, 4'b0110, 4'hA, 4, 2);

        // R11: back-to-back single-phase transactions with no idle clock.
        cur_req = "R11";
        for (int i = 0; i < 400; i++) begin
            idsel = 1'($urandom);
            ioen  = ($urandom % 5) != 0;
            memen = ($urandom % 5) != 0;
            txn(pick_addr($urandom), 4'($urandom), 4'($urandom),
                1 + ($urandom % 3), ($urandom % 3 == 0) ? 1 : 0);
        end
        drive(1'b1, 32'h0, 4'hF);
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            misses++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule